// File: doc/BRIEF.md
# Stream Attribute Symbol Serializer

This block turns one set of video timing attributes into a fixed burst of nine 32-bit link symbols. The attributes are horizontal and vertical total, active start and active size, the two sync widths with their polarities, a 48-bit pixel frequency and two miscellaneous format bytes. Each symbol carries one byte per lane on four lanes. Lane N sits in `sym_data[8N+7:8N]`. The burst leaves on a valid/ready interface, and `sym_last` marks the ninth symbol.

Software loads attributes through a write strobe. When `dbuf_en` is low, a write lands in the active set at once. This is the mode for bringing up a stream. When `dbuf_en` is high, a write lands in a shadow set. The shadow set moves to the active set at the next frame-start pulse that arrives while no burst is in flight. This lets a running stream change format without a torn burst.

The control is a two-state machine. IDLE moves to SEND on a start pulse (IDLE_TO_SEND). SEND stays in SEND and steps to the next symbol on each accepted beat (SEND_ADVANCE). When the last symbol is accepted, SEND either restarts at symbol 0 because a start is queued (SEND_RESTART) or returns to IDLE (SEND_TO_IDLE).

Top module: `msa_symbol_serializer`

## Requirements
- R1: Symbols 0, 1 and 2 carry zero on lanes 0–2. On lane 3 they carry pixel-frequency bits [47:40], [39:32] and [31:24], in that order.
- R2: Symbol 3 carries the high bytes of h_total, h_start and h_width on lanes 0, 1 and 2, and frequency bits [23:16] on lane 3. Symbol 4 carries the low bytes of the same three fields on the same lanes, and frequency bits [15:8] on lane 3.
- R3: Symbol 5 carries the high bytes of v_total, v_start and v_height on lanes 0–2, and frequency bits [7:0] on lane 3. Symbol 6 carries the low bytes of those fields on lanes 0–2, and misc0 on lane 3.
- R4: In symbol 7, lane 0 is {hsync_pos, hsync_width[14:8]} and lane 1 is {vsync_pos, vsync_width[14:8]}. Lane 2 is zero and lane 3 is misc1.
- R5: Symbol 8 carries hsync_width[7:0] on lane 0 and vsync_width[7:0] on lane 1. Lanes 2 and 3 are zero.
- R6: While `sym_valid` is high and `sym_ready` is low, `sym_data` and `sym_last` hold their values into the next cycle.
- R7: A burst is nine back-to-back valid symbols. `sym_last` is high on the ninth symbol and on no other.
- R8: With `dbuf_en` low, a write strobe updates the active attributes, and the next burst carries the new values.
- R9: With `dbuf_en` high, a write goes only to the shadow set, and later bursts keep the old values. The shadow set becomes active at a `frame_start` pulse only while no burst is in flight. A `frame_start` pulse during a burst is ignored: both that burst and the following one keep the old values.
- R10: A start pulse in IDLE raises `sym_valid` on the next cycle. Start pulses during a burst queue exactly one further burst, which follows the last symbol with no gap. Extra start pulses are dropped.
- R11: After reset, `sym_valid` and `sym_last` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| attr_we | input | 1 | Attribute write strobe |
| dbuf_en | input | 1 | Route writes to the shadow set |
| h_total | input | 16 | Horizontal total |
| h_start | input | 16 | Horizontal active start |
| h_width | input | 16 | Horizontal active width |
| v_total | input | 16 | Vertical total |
| v_start | input | 16 | Vertical active start |
| v_height | input | 16 | Vertical active height |
| hsync_width | input | 15 | Horizontal sync width |
| vsync_width | input | 15 | Vertical sync width |
| hsync_pos | input | 1 | Horizontal sync positive polarity |
| vsync_pos | input | 1 | Vertical sync positive polarity |
| pix_freq | input | 48 | Pixel frequency value |
| misc0 | input | 8 | Format byte 0 |
| misc1 | input | 8 | Format byte 1 |
| frame_start | input | 1 | Frame boundary pulse for the shadow commit |
| burst_start | input | 1 | Request one attribute burst |
| sym_ready | input | 1 | Downstream accepts the symbol |
| sym_valid | output | 1 | Symbol on sym_data is valid |
| sym_data | output | 32 | Four lane bytes, lane N at bits 8N+7:8N |
| sym_last | output | 1 | Marks the ninth symbol |

## Verification
The hold check relies on one assumption about the inputs. An immediate write, with `attr_we` high and `dbuf_en` low, never happens while a burst is being sent. Such a write would legitimately change the data of a stalled symbol. The stimulus therefore makes every immediate write while the block is idle. It changes attributes during a burst only through the shadow path, together with frame-start pulses placed inside the burst. Ready is randomised per cycle, and start pulses are timed by cycle count from the first valid beat, so each one lands inside the burst.

// File: rtl/msa_pkg.sv
package msa_pkg;
    localparam int TIME_W  = 16;
    localparam int SYNC_W  = 15;
    localparam int FREQ_W  = 48;
    localparam int MISC_W  = 8;
    localparam int LANES   = 4;
    localparam int LANE_W  = 8;
    localparam int SYM_W   = LANES * LANE_W;
    localparam int NUM_SYM = 9;
    localparam int IDX_W   = $clog2(NUM_SYM);

    typedef struct packed {
        logic [TIME_W-1:0] h_total;
        logic [TIME_W-1:0] h_start;
        logic [TIME_W-1:0] h_width;
        logic [TIME_W-1:0] v_total;
        logic [TIME_W-1:0] v_start;
        logic [TIME_W-1:0] v_height;
        logic [SYNC_W-1:0] hs_w;
        logic [SYNC_W-1:0] vs_w;
        logic              hs_pos;
        logic              vs_pos;
        logic [FREQ_W-1:0] freq;
        logic [MISC_W-1:0] misc0;
        logic [MISC_W-1:0] misc1;
    } msa_attr_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } msa_state_e;
endpackage

// File: rtl/msa_attr_bank.sv
module msa_attr_bank
    import msa_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      dbuf_en,
    input  msa_attr_t wr_attr,
    input  logic      commit,
    output msa_attr_t active
);
    msa_attr_t shadow_q;
    msa_attr_t active_q;
    logic      pending_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q  <= '0;
            active_q  <= '0;
            pending_q <= 1'b0;
        end else begin
            if (commit && pending_q) begin
                active_q  <= shadow_q;
                pending_q <= 1'b0;
            end
            if (wr_en && !dbuf_en) begin
                active_q <= wr_attr;
            end
            if (wr_en && dbuf_en) begin
                shadow_q  <= wr_attr;
                pending_q <= 1'b1;
            end
        end
    end

    assign active = active_q;
endmodule

// File: rtl/msa_burst_fsm.sv
module msa_burst_fsm
    import msa_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ready,
    output logic             valid,
    output logic             last,
    output logic             busy,
    output logic [IDX_W-1:0] beat
);
    localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(NUM_SYM - 1);

    msa_state_e       state_q, state_d;
    logic [IDX_W-1:0] beat_q, beat_d;
    logic             queued_q, queued_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            beat_q   <= '0;
            queued_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            beat_q   <= beat_d;
            queued_q <= queued_d;
        end
    end

    // transitions
    always_comb begin
        state_d  = state_q;
        beat_d   = beat_q;
        queued_d = queued_q;
        unique case (state_q)
            ST_IDLE: begin
                queued_d = 1'b0;
                if (start) begin
                    state_d = ST_SEND;          // IDLE_TO_SEND
                    beat_d  = '0;
                end
            end
            ST_SEND: begin
                queued_d = queued_q | start;
                if (ready) begin
                    if (beat_q == LAST_BEAT) begin
                        beat_d = '0;
                        if (queued_d) begin
                            queued_d = 1'b0;    // SEND_RESTART
                        end else begin
                            state_d = ST_IDLE;  // SEND_TO_IDLE
                        end
                    end else begin
                        beat_d = beat_q + 1'b1; // SEND_ADVANCE
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        valid = (state_q == ST_SEND);
        busy  = valid;
        last  = valid && (beat_q == LAST_BEAT);
        beat  = beat_q;
    end
endmodule

// File: rtl/msa_symbol_mux.sv
module msa_symbol_mux
    import msa_pkg::*;
(
    input  msa_attr_t        attr,
    input  logic [IDX_W-1:0] idx,
    output logic [SYM_W-1:0] sym
);
    logic [LANE_W-1:0] lane [LANES];

    always_comb begin
        for (int i = 0; i < LANES; i++) lane[i] = '0;
        unique case (idx)
            4'd0: lane[3] = attr.freq[47:40];
            4'd1: lane[3] = attr.freq[39:32];
            4'd2: lane[3] = attr.freq[31:24];
            4'd3: begin
                lane[0] = attr.h_total[15:8];
                lane[1] = attr.h_start[15:8];
                lane[2] = attr.h_width[15:8];
                lane[3] = attr.freq[23:16];
            end
            4'd4: begin
                lane[0] = attr.h_total[7:0];
                lane[1] = attr.h_start[7:0];
                lane[2] = attr.h_width[7:0];
                lane[3] = attr.freq[15:8];
            end
            4'd5: begin
                lane[0] = attr.v_total[15:8];
                lane[1] = attr.v_start[15:8];
                lane[2] = attr.v_height[15:8];
                lane[3] = attr.freq[7:0];
            end
            4'd6: begin
                lane[0] = attr.v_total[7:0];
                lane[1] = attr.v_start[7:0];
                lane[2] = attr.v_height[7:0];
                lane[3] = attr.misc0;
            end
            4'd7: begin
                lane[0] = {attr.hs_pos, attr.hs_w[14:8]};
                lane[1] = {attr.vs_pos, attr.vs_w[14:8]};
                lane[3] = attr.misc1;
            end
            4'd8: begin
                lane[0] = attr.hs_w[7:0];
                lane[1] = attr.vs_w[7:0];
            end
            default: ;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_pack
        assign sym[g*LANE_W +: LANE_W] = lane[g];
    end
endmodule

// File: rtl/msa_symbol_serializer.sv
module msa_symbol_serializer
    import msa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              attr_we,
    input  logic              dbuf_en,
    input  logic [TIME_W-1:0] h_total,
    input  logic [TIME_W-1:0] h_start,
    input  logic [TIME_W-1:0] h_width,
    input  logic [TIME_W-1:0] v_total,
    input  logic [TIME_W-1:0] v_start,
    input  logic [TIME_W-1:0] v_height,
    input  logic [SYNC_W-1:0] hsync_width,
    input  logic [SYNC_W-1:0] vsync_width,
    input  logic              hsync_pos,
    input  logic              vsync_pos,
    input  logic [FREQ_W-1:0] pix_freq,
    input  logic [MISC_W-1:0] misc0,
    input  logic [MISC_W-1:0] misc1,
    input  logic              frame_start,
    input  logic              burst_start,
    input  logic              sym_ready,
    output logic              sym_valid,
    output logic [SYM_W-1:0]  sym_data,
    output logic              sym_last
);
    msa_attr_t        wr_attr;
    msa_attr_t        active;
    logic             busy;
    logic [IDX_W-1:0] beat;

    always_comb begin
        wr_attr.h_total  = h_total;
        wr_attr.h_start  = h_start;
        wr_attr.h_width  = h_width;
        wr_attr.v_total  = v_total;
        wr_attr.v_start  = v_start;
        wr_attr.v_height = v_height;
        wr_attr.hs_w     = hsync_width;
        wr_attr.vs_w     = vsync_width;
        wr_attr.hs_pos   = hsync_pos;
        wr_attr.vs_pos   = vsync_pos;
        wr_attr.freq     = pix_freq;
        wr_attr.misc0    = misc0;
        wr_attr.misc1    = misc1;
    end

    msa_attr_bank bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (attr_we),
        .dbuf_en (dbuf_en),
        .wr_attr (wr_attr),
        .commit  (frame_start && !busy),
        .active  (active)
    );

    msa_burst_fsm fsm_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (burst_start),
        .ready (sym_ready),
        .valid (sym_valid),
        .last  (sym_last),
        .busy  (busy),
        .beat  (beat)
    );

    msa_symbol_mux mux_i (
        .attr (active),
        .idx  (beat),
        .sym  (sym_data)
    );
endmodule

// File: rtl/msa_serializer_chk.sv
module msa_serializer_chk
    import msa_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             burst_start,
    input logic             sym_ready,
    input logic             sym_valid,
    input logic [SYM_W-1:0] sym_data,
    input logic             sym_last
);
    logic [IDX_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sym_valid && sym_ready) begin
            cnt_q <= (cnt_q == IDX_W'(NUM_SYM - 1)) ? '0 : cnt_q + 1'b1;
        end
    end

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid && !sym_ready |=> sym_valid && $stable(sym_data) && $stable(sym_last));

    // R7
    last_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> (sym_last == (cnt_q == IDX_W'(NUM_SYM - 1))));

    // R7
    burst_no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid && !sym_last |=> sym_valid);

    // R10
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid && burst_start |=> sym_valid);

    // R11
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !sym_valid && !sym_last);
endmodule

bind msa_symbol_serializer msa_serializer_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .burst_start (burst_start),
    .sym_ready   (sym_ready),
    .sym_valid   (sym_valid),
    .sym_data    (sym_data),
    .sym_last    (sym_last)
);

// File: tb/msa_symbol_serializer_tb_top.sv
module msa_symbol_serializer_tb_top;
    import msa_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic attr_we = 1'b0, dbuf_en = 1'b0;
    msa_attr_t drv = '0;
    logic frame_start = 1'b0, burst_start = 1'b0, sym_ready = 1'b0;
    logic sym_valid, sym_last;
    logic [SYM_W-1:0] sym_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    msa_attr_t act_m;
    msa_attr_t shd_m;

    always #2.5 clk = ~clk;

    msa_symbol_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .attr_we(attr_we), .dbuf_en(dbuf_en),
        .h_total(drv.h_total), .h_start(drv.h_start), .h_width(drv.h_width),
        .v_total(drv.v_total), .v_start(drv.v_start), .v_height(drv.v_height),
        .hsync_width(drv.hs_w), .vsync_width(drv.vs_w),
        .hsync_pos(drv.hs_pos), .vsync_pos(drv.vs_pos),
        .pix_freq(drv.freq), .misc0(drv.misc0), .misc1(drv.misc1),
        .frame_start(frame_start), .burst_start(burst_start), .sym_ready(sym_ready),
        .sym_valid(sym_valid), .sym_data(sym_data), .sym_last(sym_last)
    );

    function automatic logic [31:0] exp_sym(msa_attr_t a, int i);
        case (i)
            0: return {a.freq[47:40], 24'h0};
            1: return {a.freq[39:32], 24'h0};
            2: return {a.freq[31:24], 24'h0};
            3: return {a.freq[23:16], a.h_width[15:8], a.h_start[15:8], a.h_total[15:8]};
            4: return {a.freq[15:8], a.h_width[7:0], a.h_start[7:0], a.h_total[7:0]};
            5: return {a.freq[7:0], a.v_height[15:8], a.v_start[15:8], a.v_total[15:8]};
            6: return {a.misc0, a.v_height[7:0], a.v_start[7:0], a.v_total[7:0]};
            7: return {a.misc1, 8'h0, a.vs_pos, a.vs_w[14:8], a.hs_pos, a.hs_w[14:8]};
            default: return {16'h0, a.vs_w[7:0], a.hs_w[7:0]};
        endcase
    endfunction

    function automatic string beat_tag(int i);
        if (i < 3) return "R1";
        if (i < 5) return "R2";
        if (i < 7) return "R3";
        if (i == 7) return "R4";
        return "R5";
    endfunction

    function automatic msa_attr_t rand_attr();
        msa_attr_t a;
        a.h_total  = 16'($urandom);
        a.h_start  = 16'($urandom);
        a.h_width  = 16'($urandom);
        a.v_total  = 16'($urandom);
        a.v_start  = 16'($urandom);
        a.v_height = 16'($urandom);
        a.hs_w     = 15'($urandom);
        a.vs_w     = 15'($urandom);
        a.hs_pos   = 1'($urandom);
        a.vs_pos   = 1'($urandom);
        a.freq     = {16'($urandom), 32'($urandom)};
        a.misc0    = 8'($urandom);
        a.misc1    = 8'($urandom);
        return a;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic write_attr(input msa_attr_t a, input bit dbuf);
        drv = a; dbuf_en = dbuf; attr_we = 1'b1;
        @(negedge clk);
        attr_we = 1'b0;
        if (dbuf) shd_m = a; else act_m = a;
    endtask

    task automatic pulse_start();
        burst_start = 1'b1;
        @(negedge clk);
        burst_start = 1'b0;
    endtask

    task automatic pulse_sof_idle();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        act_m = shd_m;
    endtask

    // one burst: n_starts pulses during it, frame_start at cycle sof_cyc (-1: none)
    task automatic collect(input msa_attr_t ex, input bit rnd, input int n_starts,
                           input int sof_cyc);
        int beat = 0;
        int cyc = 0;
        int w = 0;
        bit held = 1'b0;
        logic [31:0] prev = '0;
        logic prev_last = 1'b0;
        while (!sym_valid && w < 20) begin
            @(negedge clk);
            w++;
        end
        chk(sym_valid, "R10", 64'(sym_valid), 64'd1, "burst launched");
        if (!sym_valid) return;
        while (beat < NUM_SYM && cyc < 300) begin
            if (held) begin
                chk(sym_data == prev && sym_last == prev_last, "R6",
                    64'(sym_data), 64'(prev), "held symbol");
            end
            chk(sym_valid, "R7", 64'(sym_valid), 64'd1, "valid within burst");
            chk(sym_data == exp_sym(ex, beat), beat_tag(beat), 64'(sym_data),
                64'(exp_sym(ex, beat)), $sformatf("symbol %0d", beat));
            chk(sym_last == (beat == NUM_SYM - 1), "R7", 64'(sym_last),
                64'(beat == NUM_SYM - 1), "last flag");
            sym_ready   = rnd ? 1'($urandom) : 1'b1;
            burst_start = (cyc == 1 && n_starts > 0) || (cyc == 3 && n_starts > 1) ||
                          (cyc == 5 && n_starts > 2);
            frame_start = (cyc == sof_cyc);
            held      = !sym_ready;
            prev      = sym_data;
            prev_last = sym_last;
            if (sym_ready) beat++;
            cyc++;
            @(negedge clk);
        end
        sym_ready = 1'b0; burst_start = 1'b0; frame_start = 1'b0;
    endtask

    task automatic expect_idle(input int n, input string what);
        for (int i = 0; i < n; i++) begin
            chk(!sym_valid, "R10", 64'(sym_valid), 64'd0, what);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        msa_attr_t a;
        msa_attr_t b;
        msa_attr_t c;
        void'($urandom(32'd2024));
        act_m = '0;
        shd_m = '0;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(!sym_valid && !sym_last, "R11", 64'({sym_valid, sym_last}), 64'd0, "reset idle");
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sym_valid, "R11", 64'(sym_valid), 64'd0, "idle after reset");

        // corner: saturated sync widths, both polarity settings (R4, R5)
        a = '1;
        write_attr(a, 1'b0);
        pulse_start();
        collect(act_m, 1'b0, 0, -1);
        a.hs_pos = 1'b0; a.vs_pos = 1'b0; a.hs_w = 15'h0100; a.vs_w = 15'h7F01;
        write_attr(a, 1'b0);
        pulse_start();
        collect(act_m, 1'b0, 0, -1);

        // R8 immediate writes with random content and random back-pressure
        for (int k = 0; k < 8; k++) begin
            write_attr(rand_attr(), 1'b0);
            pulse_start();
            collect(act_m, 1'b1, 0, -1);
            expect_idle(3, "no extra burst");
        end

        // R9 shadow write is not visible until frame_start while idle
        b = rand_attr();
        write_attr(b, 1'b1);
        pulse_start();
        collect(act_m, 1'b1, 0, -1);
        pulse_sof_idle();
        pulse_start();
        collect(act_m, 1'b1, 0, -1);
        chk(act_m == b, "R9", 64'(act_m.freq), 64'(b.freq), "model committed");

        // R9 frame_start during a burst is ignored
        c = rand_attr();
        write_attr(c, 1'b1);
        pulse_start();
        collect(act_m, 1'b1, 0, 2);
        pulse_start();
        collect(act_m, 1'b1, 0, -1);
        pulse_sof_idle();
        pulse_start();
        collect(act_m, 1'b1, 0, -1);

        // R10 one queued burst, extra starts dropped
        pulse_start();
        collect(act_m, 1'b1, 1, -1);
        collect(act_m, 1'b1, 0, -1);
        expect_idle(4, "single queue R10");
        pulse_start();
        collect(act_m, 1'b0, 3, -1);
        chk(sym_valid, "R10", 64'(sym_valid), 64'd1, "queued burst follows at once");
        collect(act_m, 1'b1, 0, -1);
        expect_idle(6, "extra starts dropped");

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule